// File: doc/BRIEF.md
# Scrambled-Map 64-Source Interrupt Controller

This block collects up to 64 interrupt sources into two 32-bit pending words and gates them with two 32-bit enable (mask) words. A source's number does not match its place in those registers. A fixed, non-arithmetic table decides which word and which bit each source occupies. A separate input-sense block reports events as one-cycle pulses on `set_i`, which is indexed by source number. The controller routes each pulse to the source's pending bit.

Software reaches the registers over a simple 32-bit word-addressed bus. It writes whole enable words. It clears pending bits by writing ones. It reads a vector word that carries the winning source number in its top six bits. A single request line tells the CPU that some enabled source is pending. Arbitration is fixed: the lowest-numbered source that is both pending and enabled wins.

Top module: `scr_irq_ctrl`

## Requirements
- R1: After reset, both enable words and both pending words are zero, `irq_o` is low and the vector word reads zero.
- R2: Sources 0–15 and 32–47 sit in the low words; sources 16–31 and 48–63 sit in the high words.
- R3: Bit positions follow a fixed map:
  - source 0 uses bit 0;
  - sources 1..15 use bit 16−n;
  - sources 16..18 use bit 18−n;
  - sources 19..30 use bit 33−n;
  - source 31 uses bit 0;
  - sources 32..47 use bit 63−n;
  - sources 48..63 use bit n−32.
- R4: Bus word addresses are 0 = enable high, 1 = enable low, 2 = pending high, 3 = pending low and 4 = vector. A write to an enable address replaces that word. An enable bit of 1 lets its source through and 0 blocks it. Writes to address 4 or to unused addresses change nothing, and unused addresses read zero.
- R5: Writing a pending address clears each bit written as 1 and leaves each bit written as 0. Writing all ones to both pending words empties them.
- R6: `irq_o` is high exactly when some pending bit has its enable bit set in the same word.
- R7: The vector word holds the lowest-numbered pending and enabled source in bits 31:26, with bits 25:0 zero. It reads zero when nothing is pending and enabled.
- R8: When a set pulse and a write-1 clear hit the same pending bit in the same cycle, the bit ends up set.
- R9: Reading any register, the vector included, has no side effect on stored state.
- R10: Sources 18 and 31 share high bit 0. An event on either sets that bit, and when it is enabled the vector reports 18.
- R11: When source 0 is the winner, the vector reads zero while `irq_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_i | input | 64 | One-cycle event pulses, bit n for source n |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Request to the CPU |

## Verification
The bench builds the block with its default parameters: 64 sources and 32-bit words. These are the only values the fixed map allows, and elaboration rejects any others. With these values, every edge of the scramble is reachable: both ends of each run in the map, the aliased pair 18/31 in high bit 0, and source 0, whose vector reads the same as "no interrupt". Priority is exercised with winners spread across both words and both halves of the source range.

// File: rtl/scr_irq_pkg.sv
package scr_irq_pkg;
   localparam int SRC_N  = 64;
   localparam int WORD_W = 32;
   localparam int IDX_W  = $clog2(SRC_N);
   localparam int BIT_W  = $clog2(WORD_W);
   localparam int VEC_LO = WORD_W - IDX_W;

   typedef enum logic [2:0] {
      A_EN_HI   = 3'd0,
      A_EN_LO   = 3'd1,
      A_PEND_HI = 3'd2,
      A_PEND_LO = 3'd3,
      A_VEC     = 3'd4
   } reg_addr_e;

   // word index: 1 = high word, 0 = low word
   function automatic logic src_word(input int n);
      return ((n / 16) % 2) == 1;
   endfunction

   function automatic logic [BIT_W-1:0] src_bit(input int n);
      int b;
      if (n == 0)       b = 0;
      else if (n < 16)  b = 16 - n;
      else if (n < 19)  b = 18 - n;
      else if (n < 31)  b = 33 - n;
      else if (n == 31) b = 0;
      else if (n < 48)  b = 63 - n;
      else              b = n - 32;
      return b[BIT_W-1:0];
   endfunction
endpackage

// File: rtl/scr_irq_route.sv
module scr_irq_route
   import scr_irq_pkg::*;
#(
   parameter int NSRC = SRC_N,
   parameter int DW   = WORD_W
) (
   input  logic [NSRC-1:0]        set_i,
   input  logic [1:0][DW-1:0]     live_w,
   output logic [1:0][DW-1:0]     set_w,
   output logic [NSRC-1:0]        live_src
);
   always_comb begin
      set_w = '0;
      for (int n = 0; n < NSRC; n++)
         set_w[src_word(n)][src_bit(n)] = set_w[src_word(n)][src_bit(n)] | set_i[n];
   end

   for (genvar n = 0; n < NSRC; n++) begin : g_live
      assign live_src[n] = live_w[src_word(n)][src_bit(n)];
   end
endmodule

// File: rtl/scr_irq_regs.sv
module scr_irq_regs
   import scr_irq_pkg::*;
#(
   parameter int DW = WORD_W,
   parameter int AW = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic [AW-1:0]       addr,
   input  logic [DW-1:0]       wdata,
   input  logic [1:0][DW-1:0]  set_w,
   output logic [1:0][DW-1:0]  en_q,
   output logic [1:0][DW-1:0]  pend_q
);
   for (genvar w = 0; w < 2; w++) begin : g_word
      localparam logic [AW-1:0] EN_A   = (w == 1) ? AW'(A_EN_HI)   : AW'(A_EN_LO);
      localparam logic [AW-1:0] PEND_A = (w == 1) ? AW'(A_PEND_HI) : AW'(A_PEND_LO);
      logic [DW-1:0] clr;
      assign clr = (wr && addr == PEND_A) ? wdata : '0;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            en_q[w]   <= '0;
            pend_q[w] <= '0;
         end else begin
            if (wr && addr == EN_A) en_q[w] <= wdata;
            pend_q[w] <= (pend_q[w] & ~clr) | set_w[w];
         end
      end
   end
endmodule

// File: rtl/scr_irq_pick.sv
module scr_irq_pick
   import scr_irq_pkg::*;
#(
   parameter int NSRC = SRC_N,
   parameter int IW   = IDX_W
) (
   input  logic [NSRC-1:0] live_src,
   output logic            any,
   output logic [IW-1:0]   idx
);
   always_comb begin
      idx = '0;
      for (int n = NSRC - 1; n >= 0; n--)
         if (live_src[n]) idx = IW'(n);
   end
   assign any = |live_src;
endmodule

// File: rtl/scr_irq_ctrl.sv
module scr_irq_ctrl
   import scr_irq_pkg::*;
#(
   parameter int NSRC = SRC_N,
   parameter int DW   = WORD_W,
   parameter int AW   = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set_i,
   input  logic            bus_wr,
   input  logic [AW-1:0]   bus_addr,
   input  logic [DW-1:0]   bus_wdata,
   output logic [DW-1:0]   bus_rdata,
   output logic            irq_o
);
   localparam int IW = $clog2(NSRC);
   localparam int VL = DW - IW;

   if (NSRC != 64 || DW != 32) begin : g_bad_size
      $error("scr_irq_ctrl: fixed map needs NSRC=64 and DW=32");
   end
   if (AW < 3) begin : g_bad_aw
      $error("scr_irq_ctrl: AW must be at least 3");
   end

   logic [1:0][DW-1:0] set_w, en_w, pend_w, live_w;
   logic [NSRC-1:0]    live_src;
   logic               any_live;
   logic [IW-1:0]      win_idx;
   logic [DW-1:0]      vec_w;

   scr_irq_route #(.NSRC(NSRC), .DW(DW)) u_route (
      .set_i(set_i), .live_w(live_w), .set_w(set_w), .live_src(live_src));

   scr_irq_regs #(.DW(DW), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
      .set_w(set_w), .en_q(en_w), .pend_q(pend_w));

   assign live_w = en_w & pend_w;

   scr_irq_pick #(.NSRC(NSRC), .IW(IW)) u_pick (
      .live_src(live_src), .any(any_live), .idx(win_idx));

   assign vec_w = any_live ? {win_idx, {VL{1'b0}}} : '0;
   assign irq_o = any_live;

   always_comb begin
      case (bus_addr)
         AW'(A_EN_HI):   bus_rdata = en_w[1];
         AW'(A_EN_LO):   bus_rdata = en_w[0];
         AW'(A_PEND_HI): bus_rdata = pend_w[1];
         AW'(A_PEND_LO): bus_rdata = pend_w[0];
         AW'(A_VEC):     bus_rdata = vec_w;
         default:        bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/scr_irq_chk.sv
module scr_irq_chk
   import scr_irq_pkg::*;
(
   input logic                    clk,
   input logic                    rst_n,
   input logic [SRC_N-1:0]        set_i,
   input logic                    bus_wr,
   input logic [2:0]              bus_addr,
   input logic [WORD_W-1:0]       bus_wdata,
   input logic                    irq_o,
   input logic [1:0][WORD_W-1:0]  en_w,
   input logic [1:0][WORD_W-1:0]  pend_w,
   input logic [WORD_W-1:0]       vec_w
);
   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (en_w == '0 && pend_w == '0));
   // R4
   en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 3'd1) |=> (en_w[0] == $past(bus_wdata)));
   // R5
   pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 3'd3 && bus_wdata[11] && !set_i[5]) |=> !pend_w[0][11]);
   // R8
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[5] |=> pend_w[0][11]);
   // R6
   no_enable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_w == '0) |-> !irq_o);
   // R7
   vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_o |-> (vec_w == '0));
   // R7
   vec_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_w[VEC_LO-1:0] == '0);
endmodule

bind scr_irq_ctrl scr_irq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .set_i(set_i), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .irq_o(irq_o), .en_w(en_w), .pend_w(pend_w), .vec_w(vec_w));

// File: tb/scr_irq_ctrl_tb.sv
module scr_irq_ctrl_tb;
   logic        clk = 0;
   logic        rst_n = 0;
   logic [63:0] set_i = '0;
   logic        bus_wr = 0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;
   int          n_chk = 0, n_bad = 0;

   always #5 clk = ~clk;

   scr_irq_ctrl u_dut (.clk(clk), .rst_n(rst_n), .set_i(set_i), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

   function automatic int exp_word(int n);
      case (n / 16)
         0, 2:    return 0;
         default: return 1;
      endcase
   endfunction

   function automatic int exp_bit(int n);
      if (n >= 48) return 16 + (n - 48);
      if (n >= 32) return 31 - (n - 32);
      if (n == 31 || n == 0) return 0;
      if (n >= 19) return 14 - (n - 19);
      if (n >= 16) return 2 - (n - 16);
      return 15 - (n - 1);
   endfunction

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 0; bus_wdata = '0;
   endtask

   task automatic rd(logic [2:0] a, output logic [31:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic pulse(logic [63:0] s);
      @(negedge clk); set_i = s;
      @(negedge clk); set_i = '0;
   endtask

   task automatic clear_all();
      wr(3'd2, 32'hFFFF_FFFF); wr(3'd3, 32'hFFFF_FFFF);
      wr(3'd0, 32'h0); wr(3'd1, 32'h0);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), d); check("R1 reset reg", d, 32'h0);
      end
      check("R1 reset irq", {31'b0, irq_o}, 32'h0);
   endtask

   task automatic t_map();
      int srcs[12] = '{0, 1, 15, 16, 18, 19, 30, 32, 47, 48, 63, 7};
      logic [31:0] hi, lo, e;
      foreach (srcs[i]) begin
         pulse(64'd1 << srcs[i]);
         rd(3'd2, hi); rd(3'd3, lo);
         e = 32'd1 << exp_bit(srcs[i]);
         check("R2 R3 map hi", hi, exp_word(srcs[i]) == 1 ? e : 32'h0);
         check("R2 R3 map lo", lo, exp_word(srcs[i]) == 0 ? e : 32'h0);
         check("R6 masked irq", {31'b0, irq_o}, 32'h0);
         clear_all();
      end
   endtask

   task automatic t_enable();
      logic [31:0] d;
      pulse(64'd1 << 40);
      wr(3'd0, 32'hFFFF_FFFF);
      check("R4 wrong word no irq", {31'b0, irq_o}, 32'h0);
      wr(3'd1, 32'h0080_0000);
      rd(3'd1, d); check("R4 enable readback", d, 32'h0080_0000);
      check("R6 irq on", {31'b0, irq_o}, 32'h1);
      rd(3'd4, d); check("R7 vector 40", d, 32'd40 << 26);
      wr(3'd4, 32'hFFFF_FFFF); wr(3'd5, 32'hFFFF_FFFF);
      rd(3'd4, d); check("R4 vector write ignored", d, 32'd40 << 26);
      rd(3'd5, d); check("R4 unused reads zero", d, 32'h0);
      rd(3'd3, d); check("R4 pending kept", d, 32'h0080_0000);
      clear_all();
   endtask

   task automatic t_clear();
      logic [31:0] d;
      pulse((64'd1 << 5) | (64'd1 << 6));
      wr(3'd3, 32'h0000_0000);
      rd(3'd3, d); check("R5 write zero keeps", d, 32'h0000_0C00);
      wr(3'd3, 32'h0000_0800);
      rd(3'd3, d); check("R5 write one clears", d, 32'h0000_0400);
      pulse(64'hFFFF_FFFF_FFFF_FFFF);
      wr(3'd2, 32'hFFFF_FFFF); wr(3'd3, 32'hFFFF_FFFF);
      rd(3'd2, d); check("R5 clear all hi", d, 32'h0);
      rd(3'd3, d); check("R5 clear all lo", d, 32'h0);
   endtask

   task automatic t_prio();
      logic [31:0] d;
      wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'hFFFF_FFFF);
      pulse((64'd1 << 50) | (64'd1 << 40) | (64'd1 << 7) | (64'd1 << 20));
      rd(3'd4, d); check("R7 lowest wins 7", d, 32'd7 << 26);
      wr(3'd3, 32'd1 << exp_bit(7));
      rd(3'd4, d); check("R7 next 20", d, 32'd20 << 26);
      rd(3'd4, d); check("R9 vector read no effect", d, 32'd20 << 26);
      wr(3'd0, 32'h0);
      rd(3'd4, d); check("R7 disable skips 20 and 50", d, 32'd40 << 26);
      clear_all();
   endtask

   task automatic t_race();
      logic [31:0] d;
      pulse(64'd1 << 5);
      @(negedge clk); set_i = 64'd1 << 5; bus_wr = 1; bus_addr = 3'd3; bus_wdata = 32'h0000_0800;
      @(negedge clk); set_i = '0; bus_wr = 0; bus_wdata = '0;
      rd(3'd3, d); check("R8 set beats clear", d, 32'h0000_0800);
      clear_all();
   endtask

   task automatic t_alias();
      logic [31:0] d;
      wr(3'd0, 32'h0000_0001);
      pulse(64'd1 << 31);
      rd(3'd2, d); check("R10 alias bit", d, 32'h1);
      rd(3'd4, d); check("R10 reported as 18", d, 32'd18 << 26);
      clear_all();
   endtask

   task automatic t_src0();
      logic [31:0] d;
      wr(3'd1, 32'hFFFF_FFFF);
      pulse((64'd1 << 0) | (64'd1 << 3));
      check("R11 irq high", {31'b0, irq_o}, 32'h1);
      rd(3'd4, d); check("R11 vector zero", d, 32'h0);
      clear_all();
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1;
            @(negedge clk);
            t_reset(); t_map(); t_enable(); t_clear();
            t_prio(); t_race(); t_alias(); t_src0();
         end
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog got=timeout exp=done");
         end
      join_any
      disable fork;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule